// File: doc/BRIEF.md
# Two-Common Multiplexed Segment Display Driver

This block drives a passive liquid-crystal panel with two common electrodes and a parameterised number of segment electrodes (23 by default) using half-duty, half-bias multiplexing. Every pin is produced as a 2-bit symbolic level code (low, mid, high), and a pad-side converter later turns each code into an analog level. A frame is split into two half-frames. Common 0 is selected in the first half-frame and common 1 in the second. The drive polarity inverts on every frame so that the panel sees no DC component. Frame timing comes from a single-cycle `tick` strobe, and each half-frame lasts a fixed number of ticks.

Display data is written one digit slot at a time through one shared write port. A slot holds eight display bits. A raw write stores the byte unchanged. A hex write converts a 4-bit value into a seven-segment pattern and stores that pattern. Writes land in a shadow store, and the shadow store is copied to the displayed latches only at a frame boundary, so a half-drawn pattern never reaches the panel. Any segment pin can instead act as a static general-purpose output. A standby input pulls every pin low.

Top module: `lcd2_driver`

## Requirements
- R1: After reset the display store is cleared, so every segment shows "off". The commons start their normal waveform in half-frame 0 of an even frame. In that state COM0 reads high, COM1 reads mid and every segment reads high.
- R2: A common that is not selected reads mid (01). The selected common reads high (10) in even frames and low (00) in odd frames. COM0 is selected in half-frame 0 and COM1 in half-frame 1, and the frame parity toggles after half-frame 1 ends.
- R3: Segment pin s shows display bit 2*s+c while common c is selected. If that bit is 1 (on), the pin drives the level opposite to the selected common. If the bit is 0 (off), the pin drives the same level as the selected common.
- R4: A half-frame lasts exactly TICKS_PER_PHASE tick pulses. Cycles without a tick never advance the waveform.
- R5: A raw write with slot number d stores raw_data bit k into display bit 8*d+k. Bits past the last display bit are dropped.
- R6: A hex write stores a seven-segment pattern into the slot, with segment a in bit 0 through g in bit 6 and bit 7 cleared. The patterns for values 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R7: A write changes no output until the next frame boundary, which falls at the end of half-frame 1. At that boundary the whole shadow store becomes visible at once.
- R8: When raw and hex writes occur in the same cycle, the raw data wins. A slot number at or above the slot count changes nothing.
- R9: A segment with its general-purpose mode bit set drives a static level: high if display bit 2*s is 1, low otherwise. It does this regardless of half-frame or polarity.
- R10: While standby is high, every common and segment pin reads low (00). Timing and stored data carry on, and normal drive resumes as soon as standby falls.
- R11: No pin ever carries the unused code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Frame timing strobe, one cycle wide |
| standby | input | 1 | Forces all pins low while high |
| gpo_mode | input | NUM_SEG | Per-segment static output select |
| raw_we | input | 1 | Raw slot write strobe |
| hex_we | input | 1 | Converted slot write strobe |
| slot_sel | input | SLOT_SEL_W | Target digit slot |
| raw_data | input | 8 | Raw slot byte |
| hex_val | input | 4 | Value for seven-segment conversion |
| com_lvl | output | 4 | Level codes of COM0 (bits 1:0) and COM1 (bits 3:2) |
| seg_lvl | output | 2*NUM_SEG | Level code of segment s at bits 2s+1:2s |

## Verification
The waveform is first exercised with a blank store and a steady tick, which separates half-frame order and frame-polarity faults from data faults. All sixteen hex values are then written to one slot, alternating with raw bytes of opposite bit density. Each pattern is checked only after a boundary, which separates decode-table errors from slot or bit mapping errors. A write checked before the boundary shows whether the shadow copy is premature. A long run with random tick gaps, writes, slot numbers past the end, mode bits and standby pulses mixes these conditions against a cycle model kept in the bench.

// File: rtl/lcd2_pkg.sv
`timescale 1ns/1ps
// Package lcd2_pkg
// Shared level codes and the hex-to-seven-segment conversion used by the
// two-common display driver. Assumes segment a sits in bit 0 through g in bit 6.
package lcd2_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } lvl_e;

    // Convert a 4-bit value to its seven-segment pattern (bit 7 always 0)
    function automatic logic [7:0] hex_to_seg7(input logic [3:0] v);
        logic [7:0] p;
        case (v)
            4'h0: p = 8'h3F;
            4'h1: p = 8'h06;
            4'h2: p = 8'h5B;
            4'h3: p = 8'h4F;
            4'h4: p = 8'h66;
            4'h5: p = 8'h6D;
            4'h6: p = 8'h7D;
            4'h7: p = 8'h07;
            4'h8: p = 8'h7F;
            4'h9: p = 8'h6F;
            4'hA: p = 8'h77;
            4'hB: p = 8'h7C;
            4'hC: p = 8'h39;
            4'hD: p = 8'h5E;
            4'hE: p = 8'h79;
            default: p = 8'h71;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lcd2_timing.sv
`timescale 1ns/1ps
// Module lcd2_timing
// Counts tick strobes into half-frames, keeps the selected-common index and
// the frame polarity, and flags the cycle on which a frame ends.
// Assumes tick is a single-cycle strobe; TICKS_PER_PHASE >= 1.
module lcd2_timing #(
    parameter int TICKS_PER_PHASE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic phase,
    output logic pol,
    output logic frame_end
);
    localparam int CNT_W = $clog2(TICKS_PER_PHASE > 1 ? TICKS_PER_PHASE : 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_PHASE - 1);

    logic [CNT_W-1:0] cnt;
    logic             phase_end;

    // Half-frame ends on the last tick of the count; frame ends after common 1
    always_comb begin
        phase_end = tick && (cnt == CNT_LAST);
        frame_end = phase_end && phase;
    end

    // Tick counter within the current half-frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (phase_end)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // Selected-common index and frame polarity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
            pol   <= 1'b0;
        end else begin
            if (phase_end)
                phase <= ~phase;
            if (frame_end)
                pol <= ~pol;
        end
    end

endmodule

// File: rtl/lcd2_store.sv
`timescale 1ns/1ps
// Module lcd2_store
// Shadow store for display bits, written one 8-bit slot at a time (raw or
// converted), and the displayed latches, which copy the shadow at frame end.
// Assumes raw_we has priority over hex_we; out-of-range slots are ignored.
module lcd2_store
    import lcd2_pkg::*;
#(
    parameter int DISP_BITS  = 46,
    parameter int SLOT_W     = 8,
    parameter int NUM_SLOTS  = 6,
    parameter int SLOT_SEL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  raw_we,
    input  logic                  hex_we,
    input  logic [SLOT_SEL_W-1:0] slot_sel,
    input  logic [SLOT_W-1:0]     raw_data,
    input  logic [3:0]            hex_val,
    input  logic                  frame_end,
    output logic [DISP_BITS-1:0]  active_bits
);
    logic [SLOT_W-1:0]    wr_byte;
    logic [NUM_SLOTS-1:0] slot_hit;
    logic [DISP_BITS-1:0] shadow;

    // Pick the byte to store: raw data wins over the converted value
    always_comb begin
        if (raw_we)
            wr_byte = raw_data;
        else
            wr_byte = SLOT_W'(hex_to_seg7(hex_val));
    end

    // One write-enable per slot from the slot number
    for (genvar d = 0; d < NUM_SLOTS; d++) begin : g_hit
        always_comb slot_hit[d] = (raw_we || hex_we) &&
                                  (slot_sel == SLOT_SEL_W'(d));
    end

    // Shadow bits, each owned by one slot position
    for (genvar b = 0; b < DISP_BITS; b++) begin : g_shadow
        localparam int SLOT = b / SLOT_W;
        localparam int POS  = b % SLOT_W;
        // Load this bit when its slot is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow[b] <= 1'b0;
            else if (slot_hit[SLOT])
                shadow[b] <= wr_byte[POS];
        end
    end

    // Displayed latches follow the shadow only at frame end
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_bits <= '0;
        else if (frame_end)
            active_bits <= shadow;
    end

endmodule

// File: rtl/lcd2_drive.sv
`timescale 1ns/1ps
// Module lcd2_drive
// Encodes the common and segment pin levels from the displayed bits, the
// selected common, the frame polarity, the per-segment static mode and standby.
// Assumes display bit 2*s+c belongs to segment s under common c.
module lcd2_drive
    import lcd2_pkg::*;
#(
    parameter int NUM_SEG = 23
) (
    input  logic [2*NUM_SEG-1:0] active_bits,
    input  logic                 phase,
    input  logic                 pol,
    input  logic                 standby,
    input  logic [NUM_SEG-1:0]   gpo_mode,
    output logic [3:0]           com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl
);
    lvl_e sel_lvl;
    lvl_e inv_lvl;

    // Level of the selected common and its opposite for this frame
    always_comb begin
        sel_lvl = pol ? LVL_LOW  : LVL_HIGH;
        inv_lvl = pol ? LVL_HIGH : LVL_LOW;
    end

    for (genvar c = 0; c < 2; c++) begin : g_com
        lvl_e lvl;
        // Common c: selected level in its half-frame, mid otherwise
        always_comb begin
            if (standby)
                lvl = LVL_LOW;
            else if (phase == 1'(c))
                lvl = sel_lvl;
            else
                lvl = LVL_MID;
        end
        assign com_lvl[2*c +: 2] = lvl;
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        lvl_e lvl;
        logic on;
        // Segment s: static output, or opposite/same level as the common
        always_comb begin
            on = phase ? active_bits[2*s+1] : active_bits[2*s];
            if (standby)
                lvl = LVL_LOW;
            else if (gpo_mode[s])
                lvl = active_bits[2*s] ? LVL_HIGH : LVL_LOW;
            else if (on)
                lvl = inv_lvl;
            else
                lvl = sel_lvl;
        end
        assign seg_lvl[2*s +: 2] = lvl;
    end

endmodule

// File: rtl/lcd2_driver.sv
`timescale 1ns/1ps
// Module lcd2_driver
// Top of the two-common multiplexed display driver: frame timing, slot store
// and level encoding. Assumes tick paces the frame and all inputs are
// synchronous to clk.
module lcd2_driver #(
    parameter int NUM_SEG         = 23,
    parameter int TICKS_PER_PHASE = 4,
    parameter int SLOT_W          = 8,
    parameter int DISP_BITS       = 2 * NUM_SEG,
    parameter int NUM_SLOTS       = (DISP_BITS + SLOT_W - 1) / SLOT_W,
    parameter int SLOT_SEL_W      = $clog2(NUM_SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  standby,
    input  logic [NUM_SEG-1:0]    gpo_mode,
    input  logic                  raw_we,
    input  logic                  hex_we,
    input  logic [SLOT_SEL_W-1:0] slot_sel,
    input  logic [SLOT_W-1:0]     raw_data,
    input  logic [3:0]            hex_val,
    output logic [3:0]            com_lvl,
    output logic [2*NUM_SEG-1:0]  seg_lvl
);
    logic                 phase;
    logic                 pol;
    logic                 frame_end;
    logic [DISP_BITS-1:0] active_bits;

    lcd2_timing #(
        .TICKS_PER_PHASE(TICKS_PER_PHASE)
    ) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .phase    (phase),
        .pol      (pol),
        .frame_end(frame_end)
    );

    lcd2_store #(
        .DISP_BITS (DISP_BITS),
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_SEL_W(SLOT_SEL_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_we     (raw_we),
        .hex_we     (hex_we),
        .slot_sel   (slot_sel),
        .raw_data   (raw_data),
        .hex_val    (hex_val),
        .frame_end  (frame_end),
        .active_bits(active_bits)
    );

    lcd2_drive #(
        .NUM_SEG(NUM_SEG)
    ) u_drive (
        .active_bits(active_bits),
        .phase      (phase),
        .pol        (pol),
        .standby    (standby),
        .gpo_mode   (gpo_mode),
        .com_lvl    (com_lvl),
        .seg_lvl    (seg_lvl)
    );

endmodule

// File: rtl/lcd2_driver_sva.sv
`timescale 1ns/1ps
// Module lcd2_driver_sva
// Checker bound into lcd2_driver; watches pin codes, timing and latch updates.
module lcd2_driver_sva #(
    parameter int NUM_SEG = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 standby,
    input logic                 phase,
    input logic                 pol,
    input logic                 frame_end,
    input logic [2*NUM_SEG-1:0] active_bits,
    input logic [3:0]           com_lvl,
    input logic [2*NUM_SEG-1:0] seg_lvl
);
    // R1: reset leaves the displayed store blank
    assert_reset_blank_R1: assert property (@(posedge clk)
        !rst_n |=> (active_bits == '0));

    // R2: outside standby exactly one common is away from mid
    assert_one_common_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !standby |-> ((com_lvl[1:0] == 2'b01) != (com_lvl[3:2] == 2'b01)));

    // R2: polarity inverts across every frame end
    assert_pol_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (pol != $past(pol)));

    // R4: no tick, no waveform advance
    assert_phase_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));

    // R7: displayed bits hold between frame ends
    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(active_bits));

    // R10: standby forces all pins low
    assert_standby_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (com_lvl == '0 && seg_lvl == '0));

    // R11: code 11 never appears on any pin
    assert_com_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (com_lvl[1:0] != 2'b11) && (com_lvl[3:2] != 2'b11));

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg_code
        assert_seg_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
            seg_lvl[2*s +: 2] != 2'b11);
    end

endmodule

bind lcd2_driver lcd2_driver_sva #(
    .NUM_SEG(NUM_SEG)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .standby    (standby),
    .phase      (phase),
    .pol        (pol),
    .frame_end  (frame_end),
    .active_bits(active_bits),
    .com_lvl    (com_lvl),
    .seg_lvl    (seg_lvl)
);

// File: tb/lcd2_driver_test.sv
`timescale 1ns/1ps
// Bench for lcd2_driver: directed corner cases plus seeded random traffic,
// compared with a cycle model built from the requirements.
module lcd2_driver_test;
    localparam int NSEG = 23;
    localparam int TPP  = 4;
    localparam int DB   = 2 * NSEG;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              standby = 1'b0;
    logic [NSEG-1:0]   gpo_mode = '0;
    logic              raw_we = 1'b0;
    logic              hex_we = 1'b0;
    logic [2:0]        slot_sel = '0;
    logic [7:0]        raw_data = '0;
    logic [3:0]        hex_val = '0;
    logic [3:0]        com_lvl;
    logic [2*NSEG-1:0] seg_lvl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lcd2_driver #(.NUM_SEG(NSEG), .TICKS_PER_PHASE(TPP)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .standby(standby),
        .gpo_mode(gpo_mode), .raw_we(raw_we), .hex_we(hex_we),
        .slot_sel(slot_sel), .raw_data(raw_data), .hex_val(hex_val),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    // Reference state
    int        m_cnt;
    bit        m_phase, m_pol;
    bit [47:0] m_shadow;
    bit [DB-1:0] m_active;

    function automatic bit [7:0] seg7(input bit [3:0] v);
        bit [7:0] t [16] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66, 8'h6D, 8'h7D, 8'h07,
                             8'h7F, 8'h6F, 8'h77, 8'h7C, 8'h39, 8'h5E, 8'h79, 8'h71};
        return t[v];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_phase <= 0; m_pol <= 0; m_shadow <= '0; m_active <= '0;
        end else begin
            if (tick) begin
                if (m_cnt == TPP - 1) begin
                    m_cnt <= 0;
                    m_phase <= ~m_phase;
                    if (m_phase) begin
                        m_pol <= ~m_pol;
                        m_active <= m_shadow[DB-1:0];
                    end
                end else m_cnt <= m_cnt + 1;
            end
            if ((raw_we || hex_we) && slot_sel < 6)
                m_shadow[slot_sel*8 +: 8] <= raw_we ? raw_data : seg7(hex_val);
        end
    end

    function automatic bit [1:0] exp_com(input int c);
        if (standby) return 2'b00;
        if (m_phase == c[0]) return m_pol ? 2'b00 : 2'b10;
        return 2'b01;
    endfunction

    function automatic bit [1:0] exp_seg(input int s);
        bit on;
        if (standby) return 2'b00;
        if (gpo_mode[s]) return m_active[2*s] ? 2'b10 : 2'b00;
        on = m_active[2*s + m_phase];
        if (on) return m_pol ? 2'b10 : 2'b00;
        return m_pol ? 2'b00 : 2'b10;
    endfunction

    task automatic check_val(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int bad = 0;
        for (int c = 0; c < 2; c++) begin
            checks++;
            if (com_lvl[2*c +: 2] !== exp_com(c)) begin
                failures++;
                $display("FAIL %s com%0d actual=%b expected=%b", req, c, com_lvl[2*c +: 2], exp_com(c));
            end
        end
        for (int s = 0; s < NSEG; s++) begin
            checks++;
            if (seg_lvl[2*s +: 2] !== exp_seg(s)) begin
                failures++;
                $display("FAIL %s seg%0d actual=%b expected=%b", req, s, seg_lvl[2*s +: 2], exp_seg(s));
            end
            if (seg_lvl[2*s +: 2] == 2'b11) bad++;
        end
        if (com_lvl[1:0] == 2'b11 || com_lvl[3:2] == 2'b11) bad++;
        check_val("R11 code11 pins", 64'(bad), 64'd0);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n, input string req);
        tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            cyc();
            check_all(req);
        end
        tick = 1'b0;
    endtask

    task automatic wr(input bit r, input bit h, input bit [2:0] sel, input bit [7:0] d, input bit [3:0] v);
        raw_we = r; hex_we = h; slot_sel = sel; raw_data = d; hex_val = v;
        cyc();
        raw_we = 0; hex_we = 0;
    endtask

    initial begin
        logic [63:0] snap;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: blank store, COM0 high, COM1 mid, all segments high
        check_val("R1 com", 64'(com_lvl), 64'h6);
        check_val("R1 seg", 64'(seg_lvl), 64'({NSEG{2'b10}}));
        check_all("R1");
        // R4: TPP-1 ticks keep half-frame 0, a gap changes nothing
        run_ticks(TPP - 1, "R4");
        check_val("R4 still phase0", 64'(com_lvl), 64'h6);
        cyc();
        check_val("R4 no tick", 64'(com_lvl), 64'h6);
        run_ticks(1, "R4");
        check_val("R4 phase1", 64'(com_lvl), 64'h9);
        // R2: next frame has inverted polarity, COM0 low
        run_ticks(TPP, "R2");
        check_val("R2 odd frame", 64'(com_lvl), 64'h4);
        // R5/R7: raw write, invisible until boundary
        snap = 64'(seg_lvl);
        wr(1, 0, 3'd0, 8'hA5, 4'h0);
        check_val("R7 before boundary", 64'(seg_lvl), snap);
        check_all("R7");
        run_ticks(2 * TPP, "R5");
        wr(1, 0, 3'd5, 8'hFF, 4'h0);
        run_ticks(2 * TPP, "R5 last slot");
        // R6: every hex value into slot 1, alternating raw bytes in slot 2
        for (int v = 0; v < 16; v++) begin
            wr(0, 1, 3'd1, 8'h00, 4'(v));
            wr(1, 0, 3'd2, (v % 2) ? 8'h0F : 8'hF0, 4'h0);
            run_ticks(2 * TPP, "R6");
        end
        // R8: raw beats hex; slot 6 and 7 ignored
        wr(1, 1, 3'd3, 8'h81, 4'h8);
        wr(1, 0, 3'd6, 8'hFF, 4'h0);
        wr(0, 1, 3'd7, 8'h00, 4'h8);
        run_ticks(2 * TPP, "R8");
        check_val("R8 slot3 seg12 com0", 64'(seg_lvl[25:24]), 64'(exp_seg(12)));
        // R9: static mode ignores phase and polarity
        gpo_mode = 23'h5AA55A;
        cyc(); check_all("R9");
        run_ticks(3 * TPP, "R9");
        gpo_mode = '0;
        // R10: standby low, then resume
        standby = 1'b1;
        cyc();
        check_val("R10 com", 64'(com_lvl), 64'h0);
        check_val("R10 seg", 64'(seg_lvl), 64'h0);
        run_ticks(TPP + 1, "R10");
        standby = 1'b0;
        cyc(); check_all("R10 resume");
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            tick = ($urandom % 2) == 0;
            raw_we = ($urandom % 10) == 0;
            hex_we = ($urandom % 10) == 0;
            slot_sel = 3'($urandom);
            raw_data = 8'($urandom);
            hex_val = 4'($urandom);
            if (($urandom % 40) == 0) standby = ~standby;
            if (($urandom % 200) == 0) gpo_mode = NSEG'($urandom);
            cyc();
            check_all("R3");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule